// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a 4-bit synchronous counter. A parameter selects the count range. In decade mode it counts 0 to 9. In binary mode it counts 0 to 15. A second parameter selects the clear. The clear can be a synchronous input that acts on the rising edge, or an asynchronous input that zeroes the counter at once.

On each rising edge the block picks one of four actions, in this priority order:

- CLEAR: the count goes to zero. This action exists only in the synchronous-clear variant.
- LOAD: the preset value is copied into the counter.
- STEP: the counter advances to its next value.
- HOLD: the count does not change.

In decade mode, STEP follows the normal 0 to 9 sequence. It also follows three fixed recovery paths out of the unused codes:

- 10 → 11 → 6
- 12 → 13 → 4
- 14 → 15 → 2

The terminal-count output is combinational. It is high only when the trickle enable is high and the count is at the maximum code. Counters can therefore be chained: each stage's terminal count drives the trickle enable of the next stage. All stages share the clock and the parallel enable.

Top module: `sync_preset_counter`

## Requirements
- R1: With `DECADE=1` and STEP taken at every edge, the count goes 0,1,...,9 and then 9 → 0. A legal code (0 to 9) never steps to a code above 9.
- R2: With `DECADE=0`, STEP increments the count by one, and 15 → 0.
- R3: In the variant with `ASYNC_CLR=0`, if `clr_n` is low at a rising edge, the count is 0 after that edge. This holds whatever the values of `load_n`, `ena_par` and `ena_trk`.
- R4: In the variant with `ASYNC_CLR=1`, a low `clr_n` forces `q` to 0 at once, with no clock edge needed. `q` stays 0 while `clr_n` is low.
- R5: With `clr_n` high and `load_n` low, `q` equals `din` after the rising edge, whatever the enables are.
- R6: With `clr_n` and `load_n` high, the count takes the STEP action only when `ena_par` and `ena_trk` are both high. Otherwise `q` holds its value.
- R7: `tc` is high exactly when `ena_trk` is high and `q` is 9 (decimal mode) or 15 (binary mode). `ena_par` has no effect on `tc`.
- R8: In decimal mode, STEP maps 10→11, 11→6, 12→13, 13→4, 14→15 and 15→2. `tc` stays low for every code from 10 to 15.
- R9: Three decimal counters can be chained, with each `tc` driving the next stage's `ena_trk` and a shared `ena_par`. The chain then counts 000 to 999 and wraps to 000. A low `ena_trk` on the first stage freezes the whole chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear, synchronous or asynchronous by parameter |
| load_n | input | 1 | Active-low preset strobe |
| ena_par | input | 1 | Count enable that does not gate `tc` |
| ena_trk | input | 1 | Count enable that also gates `tc` |
| din | input | 4 | Preset value |
| q | output | 4 | Current count |
| tc | output | 1 | Terminal count, gated by `ena_trk` |

## Verification
The effect of CLEAR, LOAD, STEP and HOLD appears on `q` one rising edge after the controls are presented. The bench changes its inputs on the falling edge and samples 1 ns after the next rising edge.

`tc` is combinational, so it is checked in the same sample window against the count that is then current and the trickle enable that is still held.

The asynchronous clear is checked 1 ns after `clr_n` falls, before any rising edge. At that point the synchronous variant must still show its old count.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
    localparam int CW = 4;

    typedef enum logic [1:0] {
        ACT_CLEAR,
        ACT_LOAD,
        ACT_STEP,
        ACT_HOLD
    } ctr_act_e;
endpackage

// File: rtl/ctr_act_sel.sv
module ctr_act_sel
    import ctr_pkg::*;
#(
    parameter bit SYNC_CLR = 1'b1
) (
    input  logic     clr_n,
    input  logic     load_n,
    input  logic     ena_par,
    input  logic     ena_trk,
    output ctr_act_e act
);
    // Priority: clear, then load, then step, then hold.
    always_comb begin
        if (SYNC_CLR && !clr_n)
            act = ACT_CLEAR;
        else if (!load_n)
            act = ACT_LOAD;
        else if (ena_par && ena_trk)
            act = ACT_STEP;
        else
            act = ACT_HOLD;
    end
endmodule

// File: rtl/ctr_step.sv
module ctr_step
    import ctr_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic [CW-1:0] cur,
    output logic [CW-1:0] nxt
);
    generate
        if (DECADE) begin : g_dec
            logic [CW-1:0] flip;
            // Toggle form: wraps 9 to 0 and sends codes 10..15 home in two steps.
            always_comb begin
                flip[0] = 1'b1;
                flip[1] = cur[0] & ~cur[3];
                flip[2] = cur[0] & cur[1];
                flip[3] = (cur[0] & cur[1] & cur[2]) | (cur[0] & cur[3]);
                nxt     = cur ^ flip;
            end
        end else begin : g_bin
            always_comb nxt = cur + 1'b1;
        end
    endgenerate
endmodule

// File: rtl/ctr_tc.sv
module ctr_tc
    import ctr_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic [CW-1:0] q,
    input  logic          ena_trk,
    output logic          tc
);
    localparam logic [CW-1:0] TOP_CODE = DECADE ? CW'(9) : {CW{1'b1}};

    always_comb tc = ena_trk & (q == TOP_CODE);
endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
    import ctr_pkg::*;
#(
    parameter bit DECADE    = 1'b1,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic          clk,
    input  logic          clr_n,
    input  logic          load_n,
    input  logic          ena_par,
    input  logic          ena_trk,
    input  logic [CW-1:0] din,
    output logic [CW-1:0] q,
    output logic          tc
);
    localparam logic [CW-1:0] TOP_CODE = DECADE ? CW'(9) : {CW{1'b1}};

    ctr_act_e      act;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;
    logic [CW-1:0] stepped;

    ctr_act_sel #(.SYNC_CLR(!ASYNC_CLR)) u_sel (
        .clr_n  (clr_n),
        .load_n (load_n),
        .ena_par(ena_par),
        .ena_trk(ena_trk),
        .act    (act)
    );

    ctr_step #(.DECADE(DECADE)) u_step (
        .cur(cnt),
        .nxt(stepped)
    );

    // Next-state selection on the chosen action.
    always_comb begin
        cnt_nxt = cnt;
        unique case (act)
            ACT_CLEAR: cnt_nxt = '0;
            ACT_LOAD:  cnt_nxt = din;
            ACT_STEP:  cnt_nxt = stepped;
            ACT_HOLD:  cnt_nxt = cnt;
        endcase
    end

    // State register: the clear style picks the sensitivity list.
    generate
        if (ASYNC_CLR) begin : g_areg
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) cnt <= '0;
                else        cnt <= cnt_nxt;
            end
        end else begin : g_sreg
            always_ff @(posedge clk) cnt <= cnt_nxt;
        end
    endgenerate

    // Outputs.
    assign q = cnt;

    ctr_tc #(.DECADE(DECADE)) u_tc (
        .q      (cnt),
        .ena_trk(ena_trk),
        .tc     (tc)
    );

    // Checks start after the first edge.
    logic past_ok = 1'b0;
    always_ff @(posedge clk) past_ok <= 1'b1;

    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!past_ok)
        !clr_n |=> q == '0);

    assert_load_R5: assert property (@(posedge clk) disable iff (!past_ok)
        (clr_n && !load_n) |=> (!clr_n || q == $past(din)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!past_ok)
        (clr_n && load_n && !(ena_par && ena_trk)) |=> (!clr_n || $stable(q)));

    assert_tc_gate_R7: assert property (@(posedge clk) disable iff (!past_ok)
        tc |-> (ena_trk && q == TOP_CODE));

    generate
        if (ASYNC_CLR) begin : g_achk
            assert_async_zero_R4: assert property (@(posedge clk) disable iff (!past_ok)
                !clr_n |-> q == '0);
        end
        if (DECADE) begin : g_dchk
            assert_legal_stays_R1: assert property (@(posedge clk) disable iff (!past_ok)
                (clr_n && load_n && ena_par && ena_trk && q <= CW'(9))
                |=> (!clr_n || q <= CW'(9)));
            assert_no_tc_illegal_R8: assert property (@(posedge clk) disable iff (!past_ok)
                (q > CW'(9)) |-> !tc);
        end else begin : g_bchk
            assert_bin_wrap_R2: assert property (@(posedge clk) disable iff (!past_ok)
                (clr_n && load_n && ena_par && ena_trk && q == TOP_CODE)
                |=> (!clr_n || q == '0));
        end
    endgenerate
endmodule

// File: tb/test_sync_preset_counter.sv
module test_sync_preset_counter;
    localparam time CLK_T = 8ns;

    logic clk = 1'b0;
    always #(CLK_T / 2) clk = ~clk;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // Shared stimulus for four single counters:
    // 0 = decimal/sync, 1 = decimal/async, 2 = binary/sync, 3 = binary/async.
    logic       s_clr = 1'b0, s_ld = 1'b1, s_ep = 1'b0, s_et = 1'b0;
    logic [3:0] s_din = '0;
    logic [3:0] qv [4];
    logic       tcv[4];
    logic [3:0] mdl[4];

    for (genvar g = 0; g < 4; g++) begin : g_dut
        sync_preset_counter #(.DECADE(g < 2), .ASYNC_CLR(g % 2 == 1)) i_sync_preset_counter (
            .clk(clk), .clr_n(s_clr), .load_n(s_ld), .ena_par(s_ep), .ena_trk(s_et),
            .din(s_din), .q(qv[g]), .tc(tcv[g])
        );
    end

    // Cascade of three decimal counters (R9).
    logic       c_clr = 1'b0, c_en = 1'b0;
    logic [3:0] cq0, cq1, cq2;
    logic       ctc0, ctc1, ctc2;

    sync_preset_counter #(.DECADE(1'b1), .ASYNC_CLR(1'b0)) i_stage0 (
        .clk(clk), .clr_n(c_clr), .load_n(1'b1), .ena_par(1'b1), .ena_trk(c_en),
        .din(4'd0), .q(cq0), .tc(ctc0));
    sync_preset_counter #(.DECADE(1'b1), .ASYNC_CLR(1'b0)) i_stage1 (
        .clk(clk), .clr_n(c_clr), .load_n(1'b1), .ena_par(1'b1), .ena_trk(ctc0),
        .din(4'd0), .q(cq1), .tc(ctc1));
    sync_preset_counter #(.DECADE(1'b1), .ASYNC_CLR(1'b0)) i_stage2 (
        .clk(clk), .clr_n(c_clr), .load_n(1'b1), .ena_par(1'b1), .ena_trk(ctc1),
        .din(4'd0), .q(cq2), .tc(ctc2));

    // Reference model written from the requirements.
    function automatic logic [3:0] ref_step(input logic [3:0] m, input bit dec);
        if (!dec) return m + 4'd1;
        case (m)
            4'd9:  return 4'd0;
            4'd10: return 4'd11;
            4'd11: return 4'd6;
            4'd12: return 4'd13;
            4'd13: return 4'd4;
            4'd14: return 4'd15;
            4'd15: return 4'd2;
            default: return m + 4'd1;
        endcase
    endfunction

    function automatic logic [3:0] ref_next(input logic [3:0] m, input bit dec,
                                            input logic clr, input logic ld,
                                            input logic ep, input logic et,
                                            input logic [3:0] d);
        if (!clr)     return 4'd0;
        if (!ld)      return d;
        if (ep && et) return ref_step(m, dec);
        return m;
    endfunction

    function automatic logic ref_tc(input logic [3:0] m, input bit dec, input logic et);
        return et && (m == (dec ? 4'd9 : 4'd15));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic clr, input logic ld, input logic ep,
                         input logic et, input logic [3:0] d);
        logic [3:0] nx[4];
        @(negedge clk);
        s_clr = clr; s_ld = ld; s_ep = ep; s_et = et; s_din = d;
        for (int k = 0; k < 4; k++) nx[k] = ref_next(mdl[k], k < 2, clr, ld, ep, et, d);
        @(posedge clk);
        #1;
        for (int k = 0; k < 4; k++) mdl[k] = nx[k];
    endtask

    task automatic compare_all(input string req);
        for (int k = 0; k < 4; k++) begin
            chk(qv[k] === mdl[k], req, qv[k], mdl[k]);
            chk(tcv[k] === ref_tc(mdl[k], k < 2, s_et), "R7 tc", tcv[k],
                ref_tc(mdl[k], k < 2, s_et));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Vector fields: clr_n, load_n, ena_par, ena_trk, din, expected q, expected tc
    // (expected values are for the decimal / synchronous-clear counter).
    localparam int NV = 18;
    localparam logic [12:0] VEC [NV] = '{
        13'b1_1_1_1_0000_0001_0,  // R1 step 0->1
        13'b1_0_0_0_1000_1000_0,  // R5 load 8 with enables low
        13'b1_1_1_1_0000_1001_1,  // R1 step to 9, tc high (R7)
        13'b1_1_0_1_0000_1001_1,  // R6 hold, R7 tc ignores ena_par
        13'b1_1_1_0_0000_1001_0,  // R6 hold, R7 tc gated off
        13'b1_1_1_1_0000_0000_0,  // R1 wrap 9->0
        13'b1_0_1_1_1010_1010_0,  // R8 preset 10
        13'b1_1_1_1_0000_1011_0,  // R8 10->11
        13'b1_1_1_1_0000_0110_0,  // R8 11->6
        13'b1_0_1_1_1100_1100_0,  // R8 preset 12
        13'b1_1_1_1_0000_1101_0,  // R8 12->13
        13'b1_1_1_1_0000_0100_0,  // R8 13->4
        13'b1_0_1_1_1110_1110_0,  // R8 preset 14
        13'b1_1_1_1_0000_1111_0,  // R8 14->15, no tc
        13'b1_1_1_1_0000_0010_0,  // R8 15->2
        13'b0_0_1_1_0101_0000_0,  // R3 clear beats load
        13'b1_0_1_1_1001_1001_1,  // R5 load 9
        13'b0_1_1_1_0000_0000_0   // R3 clear beats step
    };

    initial begin
        #(CLK_T * 200000);
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [15:0] r;
        int          held;
        for (int k = 0; k < 4; k++) mdl[k] = '0;

        // Reset: clear low for two edges.
        repeat (2) apply(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
        compare_all("R3 R4 reset");

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:5]);
            chk(qv[0] === VEC[i][4:1], "R1 R3 R5 R6 R8 table q", qv[0], VEC[i][4:1]);
            chk(tcv[0] === VEC[i][0], "R7 R8 table tc", tcv[0], VEC[i][0]);
            compare_all("R1 R2 R5 R6 R8 table model");
        end

        // Binary wrap: load 15, then step (R2).
        apply(1'b1, 1'b0, 1'b0, 1'b0, 4'd15);
        chk(tcv[2] === 1'b0, "R7 binary tc gated", tcv[2], 0);
        apply(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
        chk(qv[2] === 4'd0, "R2 binary 15->0", qv[2], 0);

        // Pseudo-random sweep over all control combinations.
        r = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
            apply(r[3:0] != 4'd0, r[6:4] != 3'd0, r[8] | r[9], r[10] | r[11], r[15:12]);
            compare_all("R1 R2 R3 R5 R6 R8 sweep");
        end

        // Asynchronous clear without a clock edge (R4).
        apply(1'b1, 1'b0, 1'b0, 1'b0, 4'd7);
        @(negedge clk);
        s_clr = 1'b0;
        #1;
        chk(qv[1] === 4'd0, "R4 async clear decimal", qv[1], 0);
        chk(qv[3] === 4'd0, "R4 async clear binary", qv[3], 0);
        chk(qv[0] === 4'd7, "R3 sync clear waits for edge", qv[0], 7);
        @(posedge clk);
        #1;
        for (int k = 0; k < 4; k++) mdl[k] = '0;
        compare_all("R3 R4 after edge");

        // Cascade: count 000..999 and wrap (R9).
        @(negedge clk);
        c_clr = 1'b1;
        c_en  = 1'b1;
        for (int i = 1; i <= 1000; i++) begin
            @(posedge clk);
            #1;
            chk(cq2 * 100 + cq1 * 10 + cq0 == i % 1000, "R9 cascade count",
                cq2 * 100 + cq1 * 10 + cq0, i % 1000);
        end

        // Freeze the chain through the first trickle enable (R9).
        @(negedge clk);
        c_en = 1'b0;
        held = cq2 * 100 + cq1 * 10 + cq0;
        repeat (5) begin
            @(posedge clk);
            #1;
            chk(cq2 * 100 + cq1 * 10 + cq0 == held, "R9 cascade freeze",
                cq2 * 100 + cq1 * 10 + cq0, held);
        end

        finish_run();
    end
endmodule